// File: doc/BRIEF.md
# Fabric Configuration Reset Sequencer

This block is the hardware sequencer that brings a reconfigurable logic fabric into a known state before a full configuration image is streamed in, and releases it afterwards. A control agent issues a start request and marks it as a full or a partial load. For a full load the sequencer first asserts every fabric domain reset. It then closes the isolation level shifters and reopens only the processor-to-fabric direction. Next it runs a program-pulse handshake against the fabric's init-status line. When the handshake succeeds it emits a one-cycle ready-for-data pulse and waits for the agent to report that configuration-done has been observed.

At completion of a full load the sequencer opens all level shifters first and only then releases the domain resets. A partial load skips every reset, isolation and pulse step, and it leaves the vectors alone at completion. Each init wait is supervised by a polling timer that counts time units from a parameterised clock divider. An expired wait aborts the load and leaves a sticky error flag.

Top module: `cfg_reset_seq`

## Requirements
- R1: After reset, prog_o is 0, dom_rst_o is 4'h0, shift_en_o is 4'h0, and busy_o, data_ready_o and timeout_err_o are all 0.
- R2: A full-load start drives dom_rst_o to 4'hF in the next cycle with shift_en_o unchanged. One cycle later shift_en_o becomes 4'h0, and one cycle after that it becomes 4'hA. Whenever shift_en_o is 4'hA, dom_rst_o is 4'hF.
- R3: After the isolation steps, prog_o goes high and the block waits until init_i is seen high. It then drives prog_o low and waits for init_i low, then drives prog_o high and waits for init_i high. init_i is sampled once every POLL_PERIOD time units of a wait. prog_o changes only while busy_o is high.
- R4: If a wait is not satisfied within POLL_LIMIT time units of entering it, the load aborts on the following cycle: timeout_err_o is 1, busy_o is 0 and dom_rst_o stays 4'hF.
- R5: If the wait condition is met at the sample that coincides with expiry, the sequence proceeds and no error is raised.
- R6: data_ready_o is a single-cycle pulse. It is issued only after the final init-high wait succeeds, or immediately for a partial load. The block then waits for done_seen_i.
- R7: On done_seen_i after a full load, shift_en_o becomes 4'hF in one cycle and dom_rst_o becomes 4'h0 in the next, at which point busy_o drops.
- R8: A start with partial_i=1 gives data_ready_o in the next cycle and leaves prog_o, dom_rst_o and shift_en_o unchanged, both then and at completion.
- R9: timeout_err_o stays 1 until the next accepted start, which clears it.
- R10: start_i is ignored while busy_o is high, and done_seen_i is ignored outside the wait for completion.
- R11: One time unit is TICK_DIV clock cycles, and the divider is realigned at each step, so an unanswered wait lasts exactly POLL_LIMIT*TICK_DIV cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only when idle |
| partial_i | input | 1 | Qualifies start: 1 selects a partial load |
| done_seen_i | input | 1 | Configuration-done has been observed |
| init_i | input | 1 | Fabric init-status line |
| prog_o | output | 1 | Program-pulse control |
| dom_rst_o | output | 4 | Fabric domain resets, 1 = asserted |
| shift_en_o | output | 4 | Level-shifter enables |
| busy_o | output | 1 | A sequence is in progress |
| data_ready_o | output | 1 | One-cycle pulse: image data may be sent |
| timeout_err_o | output | 1 | Sticky init-wait timeout flag |

## Verification
The two functions that can fall in the same cycle are the final sample of an init wait and the expiry of that wait's timeout. With the poll limit a multiple of the poll period, the last sample and the expiry share one tick. The bench holds init low through the first wait and raises it two cycles before that shared tick. It then judges the outcome at the ports: prog_o must have fallen, busy_o must still be high and timeout_err_o must be 0. A separate run keeps init low and checks that the abort arrives exactly POLL_LIMIT*TICK_DIV cycles after the wait starts.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  localparam int unsigned VEC_W = 4;

  localparam logic [VEC_W-1:0] VEC_NONE   = 4'h0;
  localparam logic [VEC_W-1:0] VEC_ALL    = 4'hF;
  localparam logic [VEC_W-1:0] SHIFT_P2F  = 4'hA;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_ALL,
    ST_ISO_OFF,
    ST_ISO_P2F,
    ST_WAIT_HI1,
    ST_WAIT_LO,
    ST_WAIT_HI2,
    ST_LOAD,
    ST_FIN_SHIFT
  } seq_state_e;
endpackage

// File: rtl/cfg_tick_div.sv
module cfg_tick_div #(
  parameter int unsigned DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr_i)              cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/cfg_poll_timer.sv
module cfg_poll_timer #(
  parameter int unsigned PERIOD = 20,
  parameter int unsigned LIMIT  = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clr_i,
  input  logic tick_i,
  output logic sample_o,
  output logic expire_o
);
  localparam int unsigned PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int unsigned LW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(PERIOD - 1);
  localparam logic [LW-1:0] L_LAST = LW'(LIMIT - 1);

  logic [PW-1:0] phase_q, phase_d;
  logic [LW-1:0] elap_q, elap_d;

  always_comb begin
    phase_d = phase_q;
    elap_d  = elap_q;
    if (!run_i || clr_i) begin
      phase_d = '0;
      elap_d  = '0;
    end else if (tick_i) begin
      phase_d = (phase_q == P_LAST) ? '0 : phase_q + 1'b1;
      elap_d  = elap_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      elap_q  <= '0;
    end else begin
      phase_q <= phase_d;
      elap_q  <= elap_d;
    end
  end

  assign sample_o = run_i && tick_i && (phase_q == P_LAST);
  assign expire_o = run_i && tick_i && (elap_q == L_LAST);

  // R3: the sample phase never leaves its range
  p_phase_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= P_LAST);
endmodule

// File: rtl/cfg_reset_seq.sv
module cfg_reset_seq
  import cfg_seq_pkg::*;
#(
  parameter int unsigned TICK_DIV    = 50,
  parameter int unsigned POLL_PERIOD = 20,
  parameter int unsigned POLL_LIMIT  = 2500000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             partial_i,
  input  logic             done_seen_i,
  input  logic             init_i,
  output logic             prog_o,
  output logic [VEC_W-1:0] dom_rst_o,
  output logic [VEC_W-1:0] shift_en_o,
  output logic             busy_o,
  output logic             data_ready_o,
  output logic             timeout_err_o
);
  seq_state_e       state_q, state_d;
  logic             prog_q, prog_d;
  logic [VEC_W-1:0] dom_q, dom_d, shift_q, shift_d;
  logic             ready_q, ready_d, err_q, err_d, part_q, part_d;
  logic             step, waiting, tick, sample, expire;

  assign step    = (state_d != state_q);
  assign waiting = (state_q == ST_WAIT_HI1) || (state_q == ST_WAIT_LO) ||
                   (state_q == ST_WAIT_HI2);

  cfg_tick_div #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr_i(step), .tick_o(tick)
  );

  cfg_poll_timer #(.PERIOD(POLL_PERIOD), .LIMIT(POLL_LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(waiting), .clr_i(step),
    .tick_i(tick), .sample_o(sample), .expire_o(expire)
  );

  always_comb begin
    state_d = state_q;
    prog_d  = prog_q;
    dom_d   = dom_q;
    shift_d = shift_q;
    ready_d = 1'b0;
    err_d   = err_q;
    part_d  = part_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        err_d  = 1'b0;
        part_d = partial_i;
        if (partial_i) begin
          state_d = ST_LOAD;
          ready_d = 1'b1;
        end else begin
          state_d = ST_RST_ALL;
          dom_d   = VEC_ALL;
        end
      end
      ST_RST_ALL: begin
        shift_d = VEC_NONE;
        state_d = ST_ISO_OFF;
      end
      ST_ISO_OFF: begin
        shift_d = SHIFT_P2F;
        state_d = ST_ISO_P2F;
      end
      ST_ISO_P2F: begin
        prog_d  = 1'b1;
        state_d = ST_WAIT_HI1;
      end
      ST_WAIT_HI1: begin
        if (sample && init_i) begin
          prog_d  = 1'b0;
          state_d = ST_WAIT_LO;
        end else if (expire) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WAIT_LO: begin
        if (sample && !init_i) begin
          prog_d  = 1'b1;
          state_d = ST_WAIT_HI2;
        end else if (expire) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WAIT_HI2: begin
        if (sample && init_i) begin
          ready_d = 1'b1;
          state_d = ST_LOAD;
        end else if (expire) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_LOAD: if (done_seen_i) begin
        if (part_q) begin
          state_d = ST_IDLE;
        end else begin
          shift_d = VEC_ALL;
          state_d = ST_FIN_SHIFT;
        end
      end
      ST_FIN_SHIFT: begin
        dom_d   = VEC_NONE;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      prog_q  <= 1'b0;
      dom_q   <= VEC_NONE;
      shift_q <= VEC_NONE;
      ready_q <= 1'b0;
      err_q   <= 1'b0;
      part_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      prog_q  <= prog_d;
      dom_q   <= dom_d;
      shift_q <= shift_d;
      ready_q <= ready_d;
      err_q   <= err_d;
      part_q  <= part_d;
    end
  end

  assign prog_o        = prog_q;
  assign dom_rst_o     = dom_q;
  assign shift_en_o    = shift_q;
  assign busy_o        = (state_q != ST_IDLE);
  assign data_ready_o  = ready_q;
  assign timeout_err_o = err_q;

  // R2: processor-to-fabric-only isolation appears only under full reset
  p_iso_under_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en_o == SHIFT_P2F) |-> (dom_rst_o == VEC_ALL));

  // R3: the program pulse moves only during a sequence
  p_prog_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prog_o) |-> busy_o);

  // R4: the error flag rises together with the return to idle
  p_err_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err_o) |-> !busy_o);

  // R6: ready-for-data lasts a single cycle
  p_ready_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready_o |=> !data_ready_o);

  // R7: resets are released only after all shifters are open
  p_release_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_rst_o == VEC_NONE && $past(dom_rst_o) == VEC_ALL) |->
      (shift_en_o == VEC_ALL));
endmodule

// File: tb/tb_cfg_reset_seq.sv
module tb_cfg_reset_seq;
  localparam int unsigned DIV = 2;
  localparam int unsigned PER = 4;
  localparam int unsigned LIM = 40;
  localparam int unsigned WIN = LIM * DIV;

  logic clk = 1'b0;
  logic rst_n, start_i, partial_i, done_seen_i, init_i;
  logic prog_o, busy_o, data_ready_o, timeout_err_o;
  logic [3:0] dom_rst_o, shift_en_o;

  int checks = 0;
  int failures = 0;

  int   fab_mode = 0;      // 0: init stuck low, 1: follows prog, 2: manual
  logic man_init = 1'b0;
  logic [2:0] dly = '0;

  always #2 clk = ~clk;

  cfg_reset_seq #(.TICK_DIV(DIV), .POLL_PERIOD(PER), .POLL_LIMIT(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .partial_i(partial_i),
    .done_seen_i(done_seen_i), .init_i(init_i), .prog_o(prog_o),
    .dom_rst_o(dom_rst_o), .shift_en_o(shift_en_o), .busy_o(busy_o),
    .data_ready_o(data_ready_o), .timeout_err_o(timeout_err_o)
  );

  // fabric model: init follows prog after three cycles
  always @(negedge clk) begin
    dly <= {dly[1:0], prog_o};
    case (fab_mode)
      1:       init_i <= dly[2];
      2:       init_i <= man_init;
      default: init_i <= 1'b0;
    endcase
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start(input logic part);
    @(negedge clk); start_i = 1'b1; partial_i = part;
    @(negedge clk); start_i = 1'b0; partial_i = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); done_seen_i = 1'b1;
    @(negedge clk); done_seen_i = 1'b0;
  endtask

  task automatic wait_ready(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk);
      if (data_ready_o) seen = 1'b1;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; partial_i = 1'b0; done_seen_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(prog_o == 1'b0 && busy_o == 1'b0 && data_ready_o == 1'b0 &&
        timeout_err_o == 1'b0, "R1 flags", {prog_o, busy_o, data_ready_o, timeout_err_o}, 0);
    chk(dom_rst_o == 4'h0 && shift_en_o == 4'h0, "R1 vectors",
        {dom_rst_o, shift_en_o}, 0);
  endtask

  task automatic t_partial();
    logic [3:0] d0, s0;
    d0 = dom_rst_o; s0 = shift_en_o;
    pulse_start(1'b1);
    chk(data_ready_o == 1'b1 && busy_o == 1'b1, "R8 immediate ready",
        {data_ready_o, busy_o}, 3);
    chk(dom_rst_o == d0 && shift_en_o == s0 && prog_o == 1'b0, "R8 vectors at start",
        {dom_rst_o, shift_en_o}, {d0, s0});
    @(negedge clk);
    chk(data_ready_o == 1'b0, "R6 ready one cycle", data_ready_o, 0);
    pulse_start(1'b0);
    chk(dom_rst_o == d0 && busy_o == 1'b1, "R10 start ignored while busy",
        dom_rst_o, d0);
    pulse_done();
    chk(busy_o == 1'b0 && dom_rst_o == d0 && shift_en_o == s0, "R8 completion untouched",
        {busy_o, dom_rst_o, shift_en_o}, {1'b0, d0, s0});
  endtask

  task automatic t_full_ok();
    int edges = 0;
    logic last;
    bit seen;
    fab_mode = 1;
    pulse_start(1'b0);
    chk(dom_rst_o == 4'hF && shift_en_o == 4'h0 && prog_o == 1'b0, "R2 step1",
        {dom_rst_o, shift_en_o}, 8'hF0);
    @(negedge clk);
    @(negedge clk);
    chk(shift_en_o == 4'hA && prog_o == 1'b0, "R2 p2f only", shift_en_o, 4'hA);
    last = prog_o;
    seen = 1'b0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk);
      if (prog_o != last) edges++;
      last = prog_o;
      if (data_ready_o) seen = 1'b1;
    end
    chk(seen, "R6 ready after handshake", seen, 1);
    chk(edges == 3 && prog_o == 1'b1, "R3 prog rise-fall-rise", edges, 3);
    @(negedge clk);
    chk(data_ready_o == 1'b0 && busy_o == 1'b1, "R6 single pulse", data_ready_o, 0);
    pulse_done();
    chk(shift_en_o == 4'hF && dom_rst_o == 4'hF && busy_o == 1'b1, "R7 shifters first",
        {shift_en_o, dom_rst_o}, 8'hFF);
    @(negedge clk);
    chk(dom_rst_o == 4'h0 && shift_en_o == 4'hF && busy_o == 1'b0, "R7 resets released",
        {dom_rst_o, busy_o}, 0);
  endtask

  task automatic t_timeout();
    int n = 0;
    fab_mode = 0;
    pulse_start(1'b0);
    chk(dom_rst_o == 4'hF && shift_en_o == 4'hF, "R2 resets before isolation",
        {dom_rst_o, shift_en_o}, 8'hFF);
    @(negedge clk);
    chk(shift_en_o == 4'h0, "R2 shifters closed", shift_en_o, 0);
    @(negedge clk);
    while (busy_o && n < 10000) begin
      @(negedge clk);
      n++;
    end
    chk(n == WIN + 1, "R4 R11 abort after limit", n, WIN + 1);
    chk(timeout_err_o == 1'b1 && dom_rst_o == 4'hF, "R4 error with resets held",
        {timeout_err_o, dom_rst_o}, 5'h1F);
    repeat (10) @(negedge clk);
    chk(timeout_err_o == 1'b1, "R9 error sticky", timeout_err_o, 1);
    pulse_start(1'b1);
    chk(timeout_err_o == 1'b0, "R9 cleared by start", timeout_err_o, 0);
    pulse_done();
    chk(dom_rst_o == 4'hF && shift_en_o == 4'hA, "R8 partial keeps aborted vectors",
        {dom_rst_o, shift_en_o}, 8'hFA);
  endtask

  task automatic t_coincide();
    bit seen;
    fab_mode = 2;
    man_init = 1'b0;
    pulse_start(1'b0);
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < int'(WIN) - 1; i++) begin
      @(negedge clk);
      done_seen_i = (i == 0);
    end
    chk(shift_en_o == 4'hA && busy_o == 1'b1, "R10 done ignored during wait",
        shift_en_o, 4'hA);
    man_init = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(prog_o == 1'b0 && busy_o == 1'b1 && timeout_err_o == 1'b0,
        "R5 final sample wins", {prog_o, busy_o, timeout_err_o}, 3'b010);
    fab_mode = 1;
    wait_ready(seen);
    chk(seen, "R3 handshake after coincidence", seen, 1);
    pulse_done();
    @(negedge clk);
    chk(dom_rst_o == 4'h0 && busy_o == 1'b0, "R7 completion", dom_rst_o, 0);
  endtask

  initial begin
    t_reset();
    t_partial();
    t_full_ok();
    t_timeout();
    t_coincide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 150000);
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
    $finish;
  end
endmodule